// File: doc/BRIEF.md
# Rotating Register File with Base Renaming

This block is a multi-ported register file for a software-pipelined loop engine. The low addresses form a static region that is always accessed directly. Above them sits a rotating region whose size is set at run time in steps of eight registers. Any read or write address that falls inside the rotating region is renamed. The block adds a rotation base to the address offset, modulo the region size, before it touches the storage array.

A loop-branch controller pulses `rotate_i` once at the end of each pipeline stage, and each pulse lowers the base by one. A value written to logical register N in one stage can therefore be read as logical register N+1 in the next stage. No data is copied. A value live for K stages occupies K consecutive rotating registers. Before a loop starts, the controller clears the base with `clr_base_i`. The region size should only be changed while the base is zero.

The block has two combinational read ports and one write port. Writes take effect on the rising clock edge.

Top module: `rot_regfile`

## Requirements
- R1: After an active-low reset, every register reads as zero and the rotation base is zero.
- R2: Logical addresses 0 to 31 are never renamed. Reads and writes to them reach the physical register with the same number, whatever the base.
- R3: The rotating region holds registers 32 to 32+S-1, where S = 8*min(rot_blocks_i, 12). Addresses at or above 32+S are not renamed. S = 0 disables renaming.
- R4: A rotating-region address n reaches physical register 32 + ((n-32) + base) mod S.
- R5: A `rotate_i` pulse lowers the base by one from the next cycle onward. A value written to logical N before the pulse reads as logical N+1 after it.
- R6: Rotating from a base of 0 gives S-1, so the renamed index wraps around the region.
- R7: `clr_base_i` sets the base to 0 on the next edge and takes priority over a rotate in the same cycle.
- R8: A write in the same cycle as a rotate is renamed with the base from before the rotate.
- R9: A read of the register being written in the same cycle returns the old value. The new value is readable from the next cycle.
- R10: The two read ports are independent; each returns the renamed contents for its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_base_i | input | 1 | Clear rotation base to zero |
| rotate_i | input | 1 | End-of-stage strobe, lowers base by one |
| rot_blocks_i | input | 4 | Rotating region size in units of 8 registers, clamped to 12 |
| we_i | input | 1 | Write enable |
| waddr_i | input | 7 | Logical write address |
| wdata_i | input | 32 | Write data |
| raddr_a_i | input | 7 | Logical read address, port A |
| rdata_a_o | output | 32 | Read data, port A |
| raddr_b_i | input | 7 | Logical read address, port B |
| rdata_b_o | output | 32 | Read data, port B |

## Verification
Read data is combinational. It is due in the same cycle as its address, and it is sampled a short delay after the inputs change at the falling edge. A write, a rotate or a base clear all take effect at the next rising edge. The bench's reference model therefore updates its array and base only after that edge, and the following samples are compared against the updated model. This ordering is what lets the same-cycle read-before-write case and the write-during-rotate case be checked exactly.

// File: rtl/rot_regfile_pkg.sv
package rot_regfile_pkg;
  localparam int unsigned STATIC_REGS = 32;
  localparam int unsigned ROT_GRAIN   = 8;
endpackage

// File: rtl/rrf_rename.sv
module rrf_rename
  import rot_regfile_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic [AW-1:0] laddr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  output logic [AW-1:0] paddr_o,
  output logic          renamed_o
);
  logic [AW-1:0] off;
  logic [AW:0]   sum;
  logic [AW:0]   wrapped;

  always_comb begin
    off       = laddr_i - AW'(STATIC_REGS);
    renamed_o = (laddr_i >= AW'(STATIC_REGS)) && (off < size_i);
    sum       = {1'b0, off} + {1'b0, base_i};
    wrapped   = (sum >= {1'b0, size_i}) ? sum - {1'b0, size_i} : sum;
    paddr_o   = renamed_o ? AW'(STATIC_REGS) + wrapped[AW-1:0] : laddr_i;
  end
endmodule

// File: rtl/rrf_base.sv
module rrf_base #(
  parameter int unsigned AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          rotate_i,
  input  logic [AW-1:0] size_i,
  output logic [AW-1:0] base_o
);
  logic [AW-1:0] base_q, base_d;

  always_comb begin
    base_d = base_q;
    if (clr_i)                         base_d = '0;
    else if (rotate_i && size_i != '0) base_d = (base_q == '0) ? size_i - 1'b1 : base_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else         base_q <= base_d;
  end

  assign base_o = base_q;

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> base_q == '0);
  assert_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rotate_i && !clr_i && size_i != '0 && base_q != '0) |=> base_q == $past(base_q) - 1'b1);
  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rotate_i && !clr_i && size_i != '0 && base_q == '0) |=> base_q == $past(size_i) - 1'b1);
endmodule

// File: rtl/rrf_array.sv
module rrf_array #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 128,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  // read-before-write: flops hold old data until the edge
  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

  assert_write_lands_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile
  import rot_regfile_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 128,
  localparam int unsigned AW      = $clog2(NUM_REGS),
  localparam int unsigned MAX_BLK = (NUM_REGS - STATIC_REGS) / ROT_GRAIN,
  localparam int unsigned BLK_W   = $clog2(MAX_BLK + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_base_i,
  input  logic              rotate_i,
  input  logic [BLK_W-1:0]  rot_blocks_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int unsigned NPORT = 3; // 0: write, 1: read A, 2: read B

  logic [BLK_W-1:0] blk_eff;
  logic [AW-1:0]    rot_size;
  logic [AW-1:0]    base;
  logic [AW-1:0]    laddr   [NPORT];
  logic [AW-1:0]    paddr   [NPORT];
  logic             renamed [NPORT];

  always_comb begin
    blk_eff  = (rot_blocks_i > BLK_W'(MAX_BLK)) ? BLK_W'(MAX_BLK) : rot_blocks_i;
    rot_size = AW'(blk_eff) * AW'(ROT_GRAIN);
  end

  assign laddr[0] = waddr_i;
  assign laddr[1] = raddr_a_i;
  assign laddr[2] = raddr_b_i;

  rrf_base #(.AW(AW)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_base_i),
    .rotate_i(rotate_i),
    .size_i  (rot_size),
    .base_o  (base)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_rename
    rrf_rename #(.AW(AW)) u_rename (
      .laddr_i  (laddr[p]),
      .base_i   (base),
      .size_i   (rot_size),
      .paddr_o  (paddr[p]),
      .renamed_o(renamed[p])
    );

    assert_static_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (laddr[p] < AW'(STATIC_REGS)) |-> (paddr[p] == laddr[p] && !renamed[p]));
    assert_in_region_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (renamed[p] && base < rot_size) |->
        ({1'b0, paddr[p]} >= (AW+1)'(STATIC_REGS) &&
         {1'b0, paddr[p]} <  (AW+1)'(STATIC_REGS) + {1'b0, rot_size}));
    assert_above_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({1'b0, laddr[p]} >= (AW+1)'(STATIC_REGS) + {1'b0, rot_size}) |-> paddr[p] == laddr[p]);
  end

  // write renamed with pre-rotate base: base register only moves at the edge
  rrf_array #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .waddr_i  (paddr[0]),
    .wdata_i  (wdata_i),
    .raddr_a_i(paddr[1]),
    .rdata_a_o(rdata_a_o),
    .raddr_b_i(paddr[2]),
    .rdata_b_o(rdata_b_o)
  );
endmodule

// File: tb/rot_regfile_tb.sv
module rot_regfile_tb;
  localparam int DW = 32;
  localparam int NR = 128;
  localparam int AW = 7;
  localparam int BW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          clr_base_i, rotate_i, we_i;
  logic [BW-1:0] rot_blocks_i;
  logic [AW-1:0] waddr_i, raddr_a_i, raddr_b_i;
  logic [DW-1:0] wdata_i, rdata_a_o, rdata_b_o;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] m_mem [NR];
  int m_base = 0;

  always #10 clk_i = ~clk_i;

  rot_regfile u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_base_i(clr_base_i), .rotate_i(rotate_i),
    .rot_blocks_i(rot_blocks_i), .we_i(we_i), .waddr_i(waddr_i), .wdata_i(wdata_i),
    .raddr_a_i(raddr_a_i), .rdata_a_o(rdata_a_o), .raddr_b_i(raddr_b_i), .rdata_b_o(rdata_b_o)
  );

  function automatic int f_size(int blk);
    return ((blk > 12) ? 12 : blk) * 8;
  endfunction

  function automatic int f_map(int a, int b, int s);
    if (a < 32 || a >= 32 + s) return a;
    return 32 + ((a - 32 + b) % s);
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(bit clr, bit rot, int blk, bit we, int wa, logic [DW-1:0] wd, int ra, int rb);
    clr_base_i = clr; rotate_i = rot; rot_blocks_i = BW'(blk);
    we_i = we; waddr_i = AW'(wa); wdata_i = wd; raddr_a_i = AW'(ra); raddr_b_i = AW'(rb);
  endtask

  // called just after a falling edge with inputs driven; checks reads, then advances model past the edge
  task automatic tick(string tag);
    int s;
    #2;
    s = f_size(int'(rot_blocks_i));
    chk(tag, rdata_a_o, m_mem[f_map(int'(raddr_a_i), m_base, s)]);
    chk(tag, rdata_b_o, m_mem[f_map(int'(raddr_b_i), m_base, s)]);
    @(posedge clk_i);
    if (we_i) m_mem[f_map(int'(waddr_i), m_base, s)] = wdata_i;
    if (clr_base_i) m_base = 0;
    else if (rotate_i && s != 0) m_base = (m_base == 0) ? s - 1 : m_base - 1;
    @(negedge clk_i);
  endtask

  task automatic peek_a(string tag, int blk, int ra, logic [DW-1:0] exp);
    drive(0, 0, blk, 0, 0, '0, ra, ra);
    #2;
    chk(tag, rdata_a_o, exp);
    tick(tag);
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NR; i++) m_mem[i] = '0;
    rst_ni = 1'b0;
    drive(0, 0, 4, 0, 0, '0, 0, 0);
    #35 rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset state
    for (int i = 0; i < NR; i += 2) begin
      drive(0, 0, 4, 0, 0, '0, i, i + 1);
      tick("R1 reset zero");
    end

    // R5: write logical 40, rotate, read logical 41 (size 32)
    drive(1, 0, 4, 0, 0, '0, 0, 0); tick("R7 clear");
    drive(0, 0, 4, 1, 40, 32'hA5A5_0040, 40, 40); tick("R5 write");
    drive(0, 1, 4, 0, 0, '0, 40, 0); tick("R5 rotate");
    peek_a("R5 shift N to N+1", 4, 41, 32'hA5A5_0040);

    // R6: rotate from 0 wraps to S-1; write logical 32 lands in physical 63
    drive(1, 0, 4, 0, 0, '0, 0, 0); tick("R7 clear");
    drive(0, 1, 4, 0, 0, '0, 0, 0); tick("R6 rotate");
    drive(0, 0, 4, 1, 32, 32'hB6B6_0063, 0, 0); tick("R6 write");
    drive(1, 0, 4, 0, 0, '0, 0, 0); tick("R7 clear");
    peek_a("R6 wrap to S-1", 4, 63, 32'hB6B6_0063);

    // R7: clear wins over rotate
    drive(1, 1, 4, 0, 0, '0, 0, 0); tick("R7 clear+rotate");
    drive(0, 0, 4, 1, 32, 32'hC7C7_0032, 0, 0); tick("R7 write");
    peek_a("R7 clear priority", 4, 32, 32'hC7C7_0032);

    // R8: write with rotate uses old base (0) -> phys 50, read as logical 51 after
    drive(0, 1, 4, 1, 50, 32'hD8D8_0050, 0, 0); tick("R8 write+rotate");
    peek_a("R8 pre-rotate base", 4, 51, 32'hD8D8_0050);

    // R9: read-before-write
    drive(0, 0, 4, 1, 5, 32'hE9E9_0005, 5, 5);
    #2; chk("R9 old value same cycle", rdata_a_o, 32'h0);
    tick("R9 same cycle");
    peek_a("R9 new value next cycle", 4, 5, 32'hE9E9_0005);

    // R2: static register unaffected by nonzero base
    drive(0, 1, 4, 0, 0, '0, 0, 0); tick("R2 rotate");
    drive(0, 0, 4, 1, 7, 32'h2222_0007, 0, 0); tick("R2 write");
    drive(1, 0, 4, 0, 0, '0, 0, 0); tick("R2 clear");
    peek_a("R2 static not renamed", 4, 7, 32'h2222_0007);

    // R3: size 8, address 45 above region not renamed
    drive(1, 0, 1, 0, 0, '0, 0, 0); tick("R3 size 8");
    drive(0, 0, 1, 1, 45, 32'h3333_0045, 0, 0); tick("R3 write");
    drive(0, 1, 1, 0, 0, '0, 0, 0); tick("R3 rotate");
    peek_a("R3 above region", 1, 45, 32'h3333_0045);

    // R3: blocks 15 clamps to 12 (size 96)
    drive(1, 0, 15, 0, 0, '0, 0, 0); tick("R3 clamp clear");
    drive(0, 0, 15, 1, 127, 32'h3C3C_0127, 0, 0); tick("R3 clamp write");
    drive(0, 1, 15, 0, 0, '0, 0, 0); tick("R3 clamp rotate");
    peek_a("R3 clamp to 96", 15, 32, 32'h3C3C_0127);

    // R4 R10: random phases
    for (int ph = 0; ph < 4; ph++) begin
      int blk;
      blk = (ph == 3) ? 0 : int'($urandom_range(1, 12));
      drive(1, 0, int'(rot_blocks_i), 0, 0, '0, 0, 0); tick("R7 phase clear");
      drive(1, 0, blk, 0, 0, '0, 0, 0); tick("R3 phase size");
      for (int c = 0; c < 600; c++) begin
        bit rot, clr, we;
        rot = ($urandom_range(0, 3) == 0);
        clr = ($urandom_range(0, 63) == 0);
        we  = $urandom_range(0, 1) == 1;
        drive(clr, rot, blk, we, int'($urandom_range(0, NR - 1)), $urandom,
              int'($urandom_range(0, NR - 1)), int'($urandom_range(0, NR - 1)));
        tick("R4 R10 random");
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule